// File: doc/BRIEF.md
# Monochrome Raster Scanout Engine

This block refreshes a one-bit-per-pixel display of 256 rows by 512 columns from a packed framebuffer of 8192 sixteen-bit words. It walks the whole frame in raster order, again and again with no pause between frames. For every group of 16 horizontally adjacent pixels it issues one read on a synchronous read port. It then shifts the returned word out one bit per clock as a pixel stream. Each pixel carries its row and column and two markers, one for the first pixel of a frame and one for the last pixel of a line.

Each row occupies 32 consecutive words. Pixel (row, col) is bit `col % 16` of word `row * 32 + col / 16`, so bit 0 of a word is the leftmost of its 16 pixels. A set bit is a black pixel. The same mapping is also offered as a separate combinational helper, so that other logic can find the word and bit that hold a given pixel.

The read for a word is issued in the cycle in which the raster counter reaches its first pixel. The serializer picks the data up one cycle later, so the pixel stream runs without gaps. Reset is synchronous and returns the raster to the top-left pixel.

Top module: `mono_scanout`

## Requirements
- R1: While `rst` is sampled high, and in the cycle after it, `pix_valid` and `fetch_en` are 0. After release, the first valid pixel is row 0, column 0 with `pix_sof` set.
- R2: `fetch_en` pulses for one cycle every 16 cycles. The word index on `fetch_addr` rises by one with each pulse from 0 to 8191 and then returns to 0, so the pulse for pixel (r, c) carries `r*32 + c/16`.
- R3: `fetch_data` is sampled in the cycle after the `fetch_en` pulse. The first pixel of that word appears on the pixel outputs two clock edges after the pulse.
- R4: The pixel at column c takes its value from bit `c % 16` of its word. Bit 0 is the leftmost pixel of the 16.
- R5: `pix_on` equals the stored bit with no inversion: 1 is black, 0 is white.
- R6: Once valid, the pixel stream has no gaps. The column rises by one each cycle, and after column 511 it returns to 0 while the row rises by one.
- R7: `pix_sof` is 1 exactly on pixel (0, 0). `pix_eol` is 1 exactly on column 511 of every row.
- R8: Pixel (255, 511) is followed in the next cycle by pixel (0, 0) of a new frame. The new frame is read afresh from the framebuffer and reflects the current contents.
- R9: The helper returns `map_word = map_row*32 + map_col/16` and `map_bit = map_col % 16`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_en | output | 1 | Read strobe to the framebuffer |
| fetch_addr | output | 13 | Word index being read |
| fetch_data | input | 16 | Word returned one cycle after the strobe |
| pix_valid | output | 1 | Pixel outputs carry a pixel |
| pix_on | output | 1 | Pixel value, 1 black, 0 white |
| pix_row | output | 8 | Row of the current pixel |
| pix_col | output | 9 | Column of the current pixel |
| pix_sof | output | 1 | First pixel of a frame |
| pix_eol | output | 1 | Last pixel of a line |
| map_row | input | 8 | Helper: pixel row |
| map_col | input | 9 | Helper: pixel column |
| map_word | output | 13 | Helper: word index holding the pixel |
| map_bit | output | 4 | Helper: bit index inside that word |

## Verification
The hardest event to reach is the frame wrap from (255, 511) back to (0, 0), together with the refetch of changed content. It occurs only once every 131072 cycles. The stimulus first resets the block in mid-frame, which also exercises the restart. It then lets a full frame run and continues several hundred pixels into the next one. The modelled framebuffer changes its contents at the moment word 0 is requested, and it places directed words (single bit at either end, all ones, all zeros) in the frame that follows the reset. As a result, the bit order and polarity are visible at the ports, and so is the fact that a fresh frame shows the new contents.

// File: rtl/mono_scanout_pkg.sv
package mono_scanout_pkg;

   localparam int unsigned DEF_ROWS   = 256;
   localparam int unsigned DEF_COLS   = 512;
   localparam int unsigned DEF_WORD_W = 16;

   function automatic bit is_pow2(int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   // Index width for a range of n values, never below one bit.
   function automatic int unsigned width_for(int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/mono_pixel_map.sv
module mono_pixel_map import mono_scanout_pkg::*; #(
   parameter int unsigned ROWS   = DEF_ROWS,
   parameter int unsigned COLS   = DEF_COLS,
   parameter int unsigned WORD_W = DEF_WORD_W,
   localparam int unsigned WPR    = COLS / WORD_W,
   localparam int unsigned ROW_W  = width_for(ROWS),
   localparam int unsigned COL_W  = width_for(COLS),
   localparam int unsigned BIT_W  = width_for(WORD_W),
   localparam int unsigned ADDR_W = width_for(ROWS * WPR)
) (
   input  logic [ROW_W-1:0]  row_i,
   input  logic [COL_W-1:0]  col_i,
   output logic [ADDR_W-1:0] word_o,
   output logic [BIT_W-1:0]  bit_o
);

   localparam int unsigned SEL_W = COL_W - BIT_W;

   // Elaboration-time parameter checks
   if (WORD_W < 2 || !is_pow2(WORD_W)) begin : g_bad_word
      $error("WORD_W must be a power of two of at least 2");
   end
   if ((COLS % WORD_W) != 0 || WPR < 2) begin : g_bad_cols
      $error("COLS must be a multiple of WORD_W holding at least two words");
   end
   if (ROWS < 2) begin : g_bad_rows
      $error("ROWS must be at least 2");
   end

   logic [SEL_W-1:0] word_in_row;

   assign bit_o       = col_i[BIT_W-1:0];
   assign word_in_row = col_i[COL_W-1:BIT_W];

   // Power-of-two geometry packs the index by concatenation; any other
   // geometry falls back to a multiply-add.
   if (is_pow2(ROWS) && is_pow2(WPR)) begin : g_concat
      assign word_o = {row_i, word_in_row};
   end else begin : g_mult
      assign word_o = ADDR_W'(int'(row_i) * int'(WPR) + int'(word_in_row));
   end

endmodule

// File: rtl/mono_scan_raster.sv
module mono_scan_raster import mono_scanout_pkg::*; #(
   parameter int unsigned ROWS   = DEF_ROWS,
   parameter int unsigned COLS   = DEF_COLS,
   parameter int unsigned WORD_W = DEF_WORD_W,
   localparam int unsigned ROW_W  = width_for(ROWS),
   localparam int unsigned COL_W  = width_for(COLS),
   localparam int unsigned BIT_W  = width_for(WORD_W),
   localparam int unsigned ADDR_W = width_for(ROWS * (COLS / WORD_W))
) (
   input  logic              clk,
   input  logic              rst,
   output logic              s0_valid_o,
   output logic [ROW_W-1:0]  s0_row_o,
   output logic [COL_W-1:0]  s0_col_o,
   output logic              fetch_en_o,
   output logic [ADDR_W-1:0] fetch_addr_o
);

   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
   localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

   logic             run_q;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;
   logic [BIT_W-1:0] lane;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= 1'b0;
         row_q <= '0;
         col_q <= '0;
      end else begin
         run_q <= 1'b1;
         if (run_q) begin
            if (col_q == COL_LAST) begin
               col_q <= '0;
               row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
            end else begin
               col_q <= col_q + 1'b1;
            end
         end
      end
   end

   mono_pixel_map #(
      .ROWS  (ROWS),
      .COLS  (COLS),
      .WORD_W(WORD_W)
   ) u_addr (
      .row_i (row_q),
      .col_i (col_q),
      .word_o(fetch_addr_o),
      .bit_o (lane)
   );

   // One read per word, issued on the word's leftmost pixel
   assign fetch_en_o = run_q && (lane == '0);
   assign s0_valid_o = run_q;
   assign s0_row_o   = row_q;
   assign s0_col_o   = col_q;

endmodule

// File: rtl/mono_scan_serializer.sv
module mono_scan_serializer import mono_scanout_pkg::*; #(
   parameter int unsigned ROWS   = DEF_ROWS,
   parameter int unsigned COLS   = DEF_COLS,
   parameter int unsigned WORD_W = DEF_WORD_W,
   localparam int unsigned ROW_W = width_for(ROWS),
   localparam int unsigned COL_W = width_for(COLS),
   localparam int unsigned BIT_W = width_for(WORD_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              s0_valid_i,
   input  logic [ROW_W-1:0]  s0_row_i,
   input  logic [COL_W-1:0]  s0_col_i,
   input  logic [WORD_W-1:0] fetch_data_i,
   output logic              pix_valid_o,
   output logic              pix_on_o,
   output logic [ROW_W-1:0]  pix_row_o,
   output logic [COL_W-1:0]  pix_col_o,
   output logic              pix_sof_o,
   output logic              pix_eol_o
);

   localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

   logic              s1_valid_q;
   logic [ROW_W-1:0]  s1_row_q;
   logic [COL_W-1:0]  s1_col_q;
   logic [WORD_W-1:0] shift_q;
   logic              word_start;

   // Stage 1 lines up position with the word the read port returns
   always_ff @(posedge clk) begin
      if (rst) begin
         s1_valid_q <= 1'b0;
         s1_row_q   <= '0;
         s1_col_q   <= '0;
      end else begin
         s1_valid_q <= s0_valid_i;
         s1_row_q   <= s0_row_i;
         s1_col_q   <= s0_col_i;
      end
   end

   assign word_start = (s1_col_q[BIT_W-1:0] == '0);

   // Stage 2: right shift, so bit 0 leaves first as the leftmost pixel
   always_ff @(posedge clk) begin
      if (rst) begin
         pix_valid_o <= 1'b0;
         pix_on_o    <= 1'b0;
         pix_row_o   <= '0;
         pix_col_o   <= '0;
         pix_sof_o   <= 1'b0;
         pix_eol_o   <= 1'b0;
         shift_q     <= '0;
      end else begin
         pix_valid_o <= s1_valid_q;
         if (s1_valid_q) begin
            pix_row_o <= s1_row_q;
            pix_col_o <= s1_col_q;
            pix_sof_o <= (s1_row_q == '0) && (s1_col_q == '0);
            pix_eol_o <= (s1_col_q == COL_LAST);
            if (word_start) begin
               pix_on_o <= fetch_data_i[0];
               shift_q  <= fetch_data_i >> 1;
            end else begin
               pix_on_o <= shift_q[0];
               shift_q  <= shift_q >> 1;
            end
         end else begin
            pix_sof_o <= 1'b0;
            pix_eol_o <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/mono_scanout.sv
module mono_scanout import mono_scanout_pkg::*; #(
   parameter int unsigned ROWS   = DEF_ROWS,
   parameter int unsigned COLS   = DEF_COLS,
   parameter int unsigned WORD_W = DEF_WORD_W,
   localparam int unsigned ROW_W  = width_for(ROWS),
   localparam int unsigned COL_W  = width_for(COLS),
   localparam int unsigned BIT_W  = width_for(WORD_W),
   localparam int unsigned ADDR_W = width_for(ROWS * (COLS / WORD_W))
) (
   input  logic              clk,
   input  logic              rst,
   output logic              fetch_en,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic [WORD_W-1:0] fetch_data,
   output logic              pix_valid,
   output logic              pix_on,
   output logic [ROW_W-1:0]  pix_row,
   output logic [COL_W-1:0]  pix_col,
   output logic              pix_sof,
   output logic              pix_eol,
   input  logic [ROW_W-1:0]  map_row,
   input  logic [COL_W-1:0]  map_col,
   output logic [ADDR_W-1:0] map_word,
   output logic [BIT_W-1:0]  map_bit
);

   logic             s0_valid;
   logic [ROW_W-1:0] s0_row;
   logic [COL_W-1:0] s0_col;

   mono_scan_raster #(
      .ROWS  (ROWS),
      .COLS  (COLS),
      .WORD_W(WORD_W)
   ) u_raster (
      .clk         (clk),
      .rst         (rst),
      .s0_valid_o  (s0_valid),
      .s0_row_o    (s0_row),
      .s0_col_o    (s0_col),
      .fetch_en_o  (fetch_en),
      .fetch_addr_o(fetch_addr)
   );

   mono_scan_serializer #(
      .ROWS  (ROWS),
      .COLS  (COLS),
      .WORD_W(WORD_W)
   ) u_ser (
      .clk         (clk),
      .rst         (rst),
      .s0_valid_i  (s0_valid),
      .s0_row_i    (s0_row),
      .s0_col_i    (s0_col),
      .fetch_data_i(fetch_data),
      .pix_valid_o (pix_valid),
      .pix_on_o    (pix_on),
      .pix_row_o   (pix_row),
      .pix_col_o   (pix_col),
      .pix_sof_o   (pix_sof),
      .pix_eol_o   (pix_eol)
   );

   mono_pixel_map #(
      .ROWS  (ROWS),
      .COLS  (COLS),
      .WORD_W(WORD_W)
   ) u_helper (
      .row_i (map_row),
      .col_i (map_col),
      .word_o(map_word),
      .bit_o (map_bit)
   );

endmodule

// File: rtl/mono_scanout_checker.sv
module mono_scanout_checker import mono_scanout_pkg::*; #(
   parameter int unsigned ROWS   = DEF_ROWS,
   parameter int unsigned COLS   = DEF_COLS,
   parameter int unsigned WORD_W = DEF_WORD_W,
   localparam int unsigned DEPTH  = ROWS * (COLS / WORD_W),
   localparam int unsigned ROW_W  = width_for(ROWS),
   localparam int unsigned COL_W  = width_for(COLS),
   localparam int unsigned BIT_W  = width_for(WORD_W),
   localparam int unsigned ADDR_W = width_for(DEPTH)
) (
   input logic              clk,
   input logic              rst,
   input logic              fetch_en,
   input logic [ADDR_W-1:0] fetch_addr,
   input logic              pix_valid,
   input logic [ROW_W-1:0]  pix_row,
   input logic [COL_W-1:0]  pix_col,
   input logic              pix_sof,
   input logic              pix_eol,
   input logic [ROW_W-1:0]  map_row,
   input logic [COL_W-1:0]  map_col,
   input logic [ADDR_W-1:0] map_word,
   input logic [BIT_W-1:0]  map_bit
);

   logic [ADDR_W-1:0] last_addr_q;
   logic              have_last_q;
   logic [ADDR_W-1:0] next_addr;

   always_ff @(posedge clk) begin
      if (rst) begin
         last_addr_q <= '0;
         have_last_q <= 1'b0;
      end else if (fetch_en) begin
         last_addr_q <= fetch_addr;
         have_last_q <= 1'b1;
      end
   end

   assign next_addr = (last_addr_q == ADDR_W'(DEPTH - 1)) ? '0 : last_addr_q + 1'b1;

   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (!pix_valid && !fetch_en));

   assert_fetch_sequence_R2: assert property (@(posedge clk) disable iff (rst)
      (fetch_en && have_last_q) |-> (fetch_addr == next_addr));

   assert_fetch_single_R2: assert property (@(posedge clk) disable iff (rst)
      fetch_en |=> !fetch_en);

   assert_no_gap_R6: assert property (@(posedge clk) disable iff (rst)
      pix_valid |=> pix_valid);

   assert_col_step_R6: assert property (@(posedge clk) disable iff (rst)
      (pix_valid && !pix_eol) |=>
         (pix_col == $past(pix_col) + COL_W'(1) && pix_row == $past(pix_row)));

   assert_row_step_R6: assert property (@(posedge clk) disable iff (rst)
      (pix_valid && pix_eol && pix_row != ROW_W'(ROWS - 1)) |=>
         (pix_col == '0 && pix_row == $past(pix_row) + ROW_W'(1)));

   assert_frame_wrap_R8: assert property (@(posedge clk) disable iff (rst)
      (pix_valid && pix_eol && pix_row == ROW_W'(ROWS - 1)) |=>
         (pix_sof && pix_row == '0 && pix_col == '0));

   assert_sof_origin_R7: assert property (@(posedge clk) disable iff (rst)
      pix_valid |-> (pix_sof == (pix_row == '0 && pix_col == '0)));

   assert_eol_last_R7: assert property (@(posedge clk) disable iff (rst)
      pix_valid |-> (pix_eol == (pix_col == COL_W'(COLS - 1))));

   always_comb begin
      if (!$isunknown({map_row, map_col})) begin
         assert_map_linear_R9: assert (int'(map_word) * int'(WORD_W) + int'(map_bit)
                                       == int'(map_row) * int'(COLS) + int'(map_col));
      end
   end

endmodule

bind mono_scanout mono_scanout_checker #(
   .ROWS  (ROWS),
   .COLS  (COLS),
   .WORD_W(WORD_W)
) u_chk (.*);

// File: tb/mono_scanout_test.sv
module mono_scanout_test;

   localparam int ROWS   = 256;
   localparam int COLS   = 512;
   localparam int WORD_W = 16;
   localparam int WPR    = COLS / WORD_W;
   localparam int DEPTH  = ROWS * WPR;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fetch_en;
   logic [12:0] fetch_addr;
   logic [15:0] fetch_data;
   logic        pix_valid, pix_on, pix_sof, pix_eol;
   logic [7:0]  pix_row;
   logic [8:0]  pix_col;
   logic [7:0]  map_row = '0;
   logic [8:0]  map_col = '0;
   logic [12:0] map_word;
   logic [3:0]  map_bit;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   mono_scanout uut (
      .clk(clk), .rst(rst),
      .fetch_en(fetch_en), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
      .pix_valid(pix_valid), .pix_on(pix_on), .pix_row(pix_row), .pix_col(pix_col),
      .pix_sof(pix_sof), .pix_eol(pix_eol),
      .map_row(map_row), .map_col(map_col), .map_word(map_word), .map_bit(map_bit)
   );

   always #2.5 clk = ~clk;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Per-frame content: the key in use changes each time word 0 is read
   logic [31:0] keys [0:7];

   function automatic logic [15:0] pat(int a, int fr);
      logic [31:0] h;
      if (fr == 1) begin
         if (a == 0)         return 16'h0001;
         if (a == 1)         return 16'h8000;
         if (a == 2)         return 16'hFFFF;
         if (a == WPR - 1)   return 16'h0000;
         if (a == DEPTH - 1) return 16'h8001;
      end
      h = (32'(a) * 32'h9E3779B1) ^ keys[fr & 7];
      h = h ^ (h >> 15);
      h = h * 32'h85EBCA6B;
      h = h ^ (h >> 13);
      return h[31:16] ^ h[15:0];
   endfunction

   // Framebuffer model: synchronous read, one cycle of latency
   int          fetch_fr = -1;
   logic [15:0] mem_q = '0;
   assign fetch_data = mem_q;

   always @(posedge clk) begin : mem_model
      int f;
      if (fetch_en) begin
         f = fetch_fr;
         if (fetch_addr == 13'd0) f = fetch_fr + 1;
         fetch_fr <= f;
         mem_q    <= pat(int'(fetch_addr), f);
      end
   end

   int cyc      = 0;
   bit rst_seen = 1'b1;
   always @(posedge clk) begin
      cyc      <= cyc + 1;
      rst_seen <= rst;
   end

   // Stream checker, sampled away from the active edge
   int exp_r = 0, exp_c = 0, exp_a = 0, out_fr = -1;
   int last_cyc = 0, zero_cyc = 0;
   bit have_last = 1'b0, prev_valid = 1'b0;

   always @(negedge clk) begin
      logic [15:0] w;
      string lbl;
      if (!done) begin
         if (rst_seen) begin
            chk(!pix_valid && !fetch_en, "R1", "outputs idle in reset",
                int'({pix_valid, fetch_en}), 0);
            exp_r = 0; exp_c = 0; exp_a = 0;
            have_last = 1'b0; prev_valid = 1'b0;
         end else begin
            if (fetch_en) begin
               chk(int'(fetch_addr) == exp_a, "R2", "fetch address", int'(fetch_addr), exp_a);
               if (have_last)
                  chk(cyc - last_cyc == WORD_W, "R2", "fetch spacing", cyc - last_cyc, WORD_W);
               if (fetch_addr == 13'd0) zero_cyc = cyc;
               last_cyc  = cyc;
               have_last = 1'b1;
               exp_a     = (exp_a + 1) % DEPTH;
            end
            if (pix_valid) begin
               if (exp_r == 0 && exp_c == 0) begin
                  out_fr++;
                  chk(cyc - zero_cyc == 2, "R3", "fetch to first pixel", cyc - zero_cyc, 2);
               end
               if (!prev_valid)                          lbl = "R1";
               else if (exp_r == 0 && exp_c == 0)        lbl = "R8";
               else                                      lbl = "R6";
               chk(int'(pix_row) == exp_r && int'(pix_col) == exp_c, lbl, "position row*1024+col",
                   int'(pix_row) * 1024 + int'(pix_col), exp_r * 1024 + exp_c);
               chk(pix_sof == (exp_r == 0 && exp_c == 0), "R7", "start of frame marker",
                   int'(pix_sof), int'(exp_r == 0 && exp_c == 0));
               chk(pix_eol == (exp_c == COLS - 1), "R7", "end of line marker",
                   int'(pix_eol), int'(exp_c == COLS - 1));
               w = pat(exp_r * WPR + exp_c / WORD_W, out_fr);
               chk(pix_on == w[exp_c % WORD_W], "R4,R5", "pixel value",
                   int'(pix_on), int'(w[exp_c % WORD_W]));
               prev_valid = 1'b1;
               if (exp_c == COLS - 1) begin
                  exp_c = 0;
                  exp_r = (exp_r == ROWS - 1) ? 0 : exp_r + 1;
               end else begin
                  exp_c++;
               end
            end else if (prev_valid) begin
               chk(1'b0, "R6", "gap in pixel stream", 0, 1);
            end
         end
      end
   end

   // Helper mapping: directed corners, then random pairs
   function automatic int exp_word(int r, int c);
      return r * WPR + c / WORD_W;
   endfunction

   initial begin : helper_checks
      int rr, cc;
      #3;
      for (int i = 0; i < 304; i++) begin
         case (i)
            0: begin rr = 0;   cc = 0;   end
            1: begin rr = 255; cc = 511; end
            2: begin rr = 1;   cc = 16;  end
            3: begin rr = 0;   cc = 15;  end
            default: begin rr = int'($urandom % ROWS); cc = int'($urandom % COLS); end
         endcase
         map_row = 8'(rr);
         map_col = 9'(cc);
         #1;
         chk(int'(map_word) == exp_word(rr, cc), "R9", "helper word index",
             int'(map_word), exp_word(rr, cc));
         chk(int'(map_bit) == cc % WORD_W, "R9", "helper bit index",
             int'(map_bit), cc % WORD_W);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin : main_seq
      void'($urandom(32'd7391));
      for (int i = 0; i < 8; i++) keys[i] = $urandom;
      repeat (5) @(posedge clk);
      #1 rst = 1'b0;
      repeat (2000) @(posedge clk);
      // Mid-frame reset: the raster must restart from the top-left pixel
      #1 rst = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      repeat (ROWS * COLS + 700) @(posedge clk);
      #1;
      chk(out_fr >= 2, "R8", "frames started after wrap", out_fr, 2);
      finish_run();
   end

   initial begin : watchdog
      #(5.0 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R6 watchdog expired: actual=%0d expected=%0d", cyc, 0);
         finish_run();
      end
   end

endmodule